// File: doc/BRIEF.md
# PWM Generator with Fault Auto-Shutdown

A single-channel pulse-width modulator with a 10-bit duty setting. The period is built from an 8-bit period value. The time base walks through (period + 1) x 4 steps, and each step lasts 1, 4 or 16 clocks, as chosen by a prescale field. Two output groups of two pins each carry the waveform. Group A carries it true and group B carries it inverted. Each group has an output enable.

An active-high fault input passes through a two-flop synchronizer. Once synchronized, it forces both groups into their programmed safe levels in the same cycle, which cuts off any pulse in progress. It also latches a shutdown status bit. The status can be cleared by a software write once the fault is gone, or it clears by itself when automatic restart is enabled. After it clears, the outputs stay safe until the next period rollover, so the first pulse after a fault is always a whole one. Software reaches all settings through a byte-wide register port with a combinational read.

The fault logic is a three-state machine:
- RUN: normal output. A synchronized fault moves it to SHUT.
- SHUT: the status bit reads 1 and the outputs are safe. It moves to HOLD once the fault is low and either auto-restart is set or software writes the status bit to 0.
- HOLD: the status bit reads 0 and the outputs are still safe. It moves to RUN at the next rollover, or back to SHUT if the fault returns.

Register map (address: contents):
- 0: period.
- 1: duty bits 9..2.
- 2: control. Bits 1..0 are duty bits 1..0, bits 3..2 select the prescale, and bit 5 enables auto-restart.
- 3: shutdown. Bit 7 is the status, bits 3..2 are the group A safe field and bits 1..0 are the group B safe field.

Top module: `pwm_fault_gen`

## Requirements
- R1: After reset, group A pins are 00 and group B pins are 11, both output enables are 1, address 0 reads FFh, and the status bit (address 3 bit 7) reads 0.
- R2: With period value P, duty D and prescale N (control bits 3..2: 00 gives 1, 01 gives 4, 1x gives 16), the group A output is high for D x N clocks of every (P+1) x 4 x N clock period, for D up to (P+1) x 4.
- R3: With prescale 1, a duty of (P+1) x 4 - 1 gives a high time one clock shorter than the period and never leaves the output stuck low.
- R4: A period value of 00h gives a valid 4-clock period that toggles, and the output is not held low.
- R5: New period, duty and prescale values take effect only at a period rollover. A write in the middle of a pulse does not change that pulse.
- R6: A high level on the fault input forces the safe levels two clocks later and ends any pulse in progress immediately.
- R7: Each group's 2-bit safe field selects the shutdown drive: 00 drives both pins low, 01 drives both pins high, and 1x turns the enable off (tri-state). The field applies only while the status is set or the outputs are held safe.
- R8: Once set, the status stays 1 while the fault is high, even if software writes bit 7 to 0. With auto-restart off, it also stays 1 after the fault ends, until software writes bit 7 to 0.
- R9: With auto-restart on (control bit 5), the status returns to 0 by itself three clocks after the fault input goes low.
- R10: After the status clears, the outputs stay safe until the next rollover. The first pulse after that is a full-length pulse.
- R11: Reading the status register has no side effect, and repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| fault_in | input | 1 | Active-high fault request (asynchronous) |
| out_a | output | 2 | Group A pins, true waveform |
| oe_a | output | 1 | Group A output enable |
| out_b | output | 2 | Group B pins, inverted waveform |
| oe_b | output | 1 | Group B output enable |

## Verification
The hardest situation to produce is the restart edge: the status has just cleared, but the period has not yet rolled over. A short pulse would appear only if the restart were not aligned to the boundary. The stimulus places the fault a few clocks into a live pulse. It then clears the status by a software write, and in a second pass by auto-restart, at an arbitrary point in the period. The scoreboard then measures the first pulse after release and requires it to have the full programmed width. Safe-field changes and ignored clear writes are applied while the fault is still held high.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SHUT = 2'd1,
        ST_HOLD = 2'd2
    } flt_state_t;

    localparam logic [1:0] ADR_PERIOD = 2'd0;
    localparam logic [1:0] ADR_DUTY   = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;
    localparam logic [1:0] ADR_SHUT   = 2'd3;

    localparam logic [1:0] SAFE_LOW  = 2'b00;
    localparam logic [1:0] SAFE_HIGH = 2'b01;
endpackage

// File: rtl/pwmf_timebase.sv
module pwmf_timebase #(
    parameter int PR_W   = 8,
    parameter int FRAC_W = 2,
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PR_W-1:0]   pr_new,
    input  logic [DUTY_W-1:0] duty_new,
    input  logic [1:0]        ps_new,
    output logic              pwm_o,
    output logic              rollover_o
);
    localparam int PS_W = 4;

    logic [PR_W-1:0]   pr_act;
    logic [DUTY_W-1:0] duty_act;
    logic [1:0]        ps_act;
    logic [DUTY_W-1:0] cnt;
    logic [PS_W-1:0]   pre;
    logic [PS_W-1:0]   pre_lim;
    logic [DUTY_W-1:0] cnt_last;
    logic              tick;

    always_comb begin
        unique case (ps_act)
            2'b00:   pre_lim = PS_W'(0);
            2'b01:   pre_lim = PS_W'(3);
            default: pre_lim = PS_W'(15);
        endcase
    end

    assign tick       = (pre == pre_lim);
    assign cnt_last   = {pr_act, {FRAC_W{1'b1}}};
    assign rollover_o = tick && (cnt == cnt_last);
    assign pwm_o      = (cnt < duty_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre      <= '0;
            cnt      <= '0;
            pr_act   <= '1;
            duty_act <= '0;
            ps_act   <= 2'b00;
        end else if (rollover_o) begin
            pre      <= '0;
            cnt      <= '0;
            pr_act   <= pr_new;
            duty_act <= duty_new;
            ps_act   <= ps_new;
        end else if (tick) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cnt_last);
    assert_duty_buffered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rollover_o |=> $stable(duty_act) && $stable(pr_act));
endmodule

// File: rtl/pwmf_fault_ctrl.sv
module pwmf_fault_ctrl
    import pwmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic auto_en,
    input  logic sw_clr,
    input  logic rollover_i,
    output logic fault_sync_o,
    output logic status_o,
    output logic safe_o
);
    logic       meta_q;
    logic       sync_q;
    flt_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= fault_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (sync_q) state_nx = ST_SHUT;
            ST_SHUT: if (!sync_q && (auto_en || sw_clr)) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (sync_q)          state_nx = ST_SHUT;
                else if (rollover_i) state_nx = ST_RUN;
            end
            default: state_nx = ST_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        fault_sync_o = sync_q;
        status_o     = (state == ST_SHUT);
        safe_o       = (state != ST_RUN) || sync_q;
    end

    assert_latch_while_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUT && sync_q) |=> state == ST_SHUT);
    assert_no_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUT && !auto_en && !sw_clr) |=> state == ST_SHUT);
    assert_wait_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rollover_i && !sync_q) |=> state == ST_HOLD);
endmodule

// File: rtl/pwm_fault_gen.sv
module pwm_fault_gen
    import pwmf_pkg::*;
#(
    parameter int PR_W   = 8,
    parameter int FRAC_W = 2,
    parameter int PINS   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            fault_in,
    output logic [PINS-1:0] out_a,
    output logic            oe_a,
    output logic [PINS-1:0] out_b,
    output logic            oe_b
);
    localparam int DUTY_W = PR_W + FRAC_W;
    localparam int GROUPS = 2;

    logic [PR_W-1:0] period_q;
    logic [7:0]      duty_hi_q;
    logic [7:0]      ctrl_q;
    logic [6:0]      shut_q;
    logic            pwm, rollover, status, safe, fault_sync, sw_clr;
    logic [1:0]      safe_sel [GROUPS];
    logic [PINS-1:0] grp_out  [GROUPS];
    logic            grp_oe   [GROUPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q  <= '1;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
            shut_q    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADR_PERIOD: period_q  <= wdata[PR_W-1:0];
                ADR_DUTY:   duty_hi_q <= wdata;
                ADR_CTRL:   ctrl_q    <= wdata;
                ADR_SHUT:   shut_q    <= wdata[6:0];
                default:    ;
            endcase
        end
    end

    assign sw_clr = wr_en && (addr == ADR_SHUT) && !wdata[7];

    always_comb begin
        unique case (addr)
            ADR_PERIOD: rdata = 8'(period_q);
            ADR_DUTY:   rdata = duty_hi_q;
            ADR_CTRL:   rdata = ctrl_q;
            default:    rdata = {status, shut_q};
        endcase
    end

    pwmf_timebase #(.PR_W(PR_W), .FRAC_W(FRAC_W), .DUTY_W(DUTY_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pr_new     (period_q),
        .duty_new   ({duty_hi_q, ctrl_q[1:0]}),
        .ps_new     (ctrl_q[3:2]),
        .pwm_o      (pwm),
        .rollover_o (rollover)
    );

    pwmf_fault_ctrl u_fc (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_in     (fault_in),
        .auto_en      (ctrl_q[5]),
        .sw_clr       (sw_clr),
        .rollover_i   (rollover),
        .fault_sync_o (fault_sync),
        .status_o     (status),
        .safe_o       (safe)
    );

    assign safe_sel[0] = shut_q[3:2];
    assign safe_sel[1] = shut_q[1:0];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_comb begin
            if (!safe) begin
                grp_out[g] = {PINS{(g == 0) ? pwm : ~pwm}};
                grp_oe[g]  = 1'b1;
            end else begin
                unique case (safe_sel[g])
                    SAFE_LOW:  begin grp_out[g] = '0; grp_oe[g] = 1'b1; end
                    SAFE_HIGH: begin grp_out[g] = '1; grp_oe[g] = 1'b1; end
                    default:   begin grp_out[g] = '0; grp_oe[g] = 1'b0; end
                endcase
            end
        end
    end

    assign out_a = grp_out[0];
    assign oe_a  = grp_oe[0];
    assign out_b = grp_out[1];
    assign oe_b  = grp_oe[1];

    assert_safe_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sync |-> (oe_a == !shut_q[3]) && (oe_b == !shut_q[1]));
    assert_tristate_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status && shut_q[3]) |-> (!oe_a && out_a == '0));
    assert_high_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status && shut_q[1:0] == SAFE_HIGH) |-> (oe_b && out_b == '1));
endmodule

// File: tb/sim_pwm_fault_gen.sv
module sim_pwm_fault_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       fault_in = 1'b0;
    logic [1:0] out_a, out_b;
    logic       oe_a, oe_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_hi_q[$];
    int exp_per_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fault_in(fault_in), .out_a(out_a), .oe_a(oe_a),
        .out_b(out_b), .oe_b(oe_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int pr, input int duty, input int ps, input bit auto_r);
        reg_wr(2'd0, 8'(pr));
        reg_wr(2'd1, 8'(duty >> 2));
        reg_wr(2'd2, {2'b00, auto_r, 1'b0, 2'(ps), 2'(duty)});
    endtask

    task automatic read_status(output logic st);
        @(negedge clk);
        addr = 2'd3;
        #1 st = rdata[7];
    endtask

    // driver: push one expected (high, period) pair
    task automatic expect_pulse(input int hi, input int per, input string tag);
        exp_hi_q.push_back(hi);
        exp_per_q.push_back(per);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        wait (exp_hi_q.size() == 0);
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (out_a[0] !== 1'b0);
        do @(negedge clk); while (out_a[0] !== 1'b1);
    endtask

    // monitor: measure one rise-to-rise window and compare with the queue head
    initial begin
        forever begin
            int hi, per, eh, ep;
            string tg;
            logic last;
            wait (exp_hi_q.size() > 0);
            wait_rise();
            hi = 0; per = 0; last = 1'b1;
            forever begin
                hi += (out_a[0] === 1'b1) ? 1 : 0;
                per++;
                last = out_a[0];
                @(negedge clk);
                if (out_a[0] === 1'b1 && last === 1'b0) break;
                if (per > 5000) break;
            end
            eh = exp_hi_q[0]; ep = exp_per_q[0]; tg = tag_q[0];
            check(hi == eh, {tg, " high time"}, hi, eh);
            check(per == ep, {tg, " period"}, per, ep);
            void'(exp_hi_q.pop_front());
            void'(exp_per_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_a == 2'b00 && oe_a, "R1 group A", int'(out_a), 0);
        check(out_b == 2'b11 && oe_b, "R1 group B", int'(out_b), 3);
        addr = 2'd0; #1;
        check(rdata == 8'hFF, "R1 period read", int'(rdata), 255);
        read_status(st);
        check(st == 1'b0, "R1 status", int'(st), 0);

        // R2 basic waveform, prescale 1
        set_cfg(9, 20, 0, 0);
        repeat (1100) @(negedge clk);
        expect_pulse(20, 40, "R2 ps1");
        drain();
        // R3 duty = period minus one
        set_cfg(9, 39, 0, 0);
        repeat (100) @(negedge clk);
        expect_pulse(39, 40, "R3 duty period-1");
        drain();
        // R4 fastest period
        set_cfg(0, 2, 0, 0);
        repeat (100) @(negedge clk);
        expect_pulse(2, 4, "R4 period 00h");
        drain();
        set_cfg(0, 3, 0, 0);
        repeat (50) @(negedge clk);
        expect_pulse(3, 4, "R4 period 00h near full");
        drain();
        // R2 prescale 4 and 16
        set_cfg(3, 5, 1, 0);
        repeat (300) @(negedge clk);
        expect_pulse(20, 64, "R2 ps4");
        drain();
        set_cfg(1, 3, 2, 0);
        repeat (300) @(negedge clk);
        expect_pulse(48, 128, "R2 ps16");
        drain();

        // R5 double buffering: write lower duty mid-pulse
        set_cfg(9, 20, 0, 0);
        repeat (300) @(negedge clk);
        wait_rise();
        repeat (3) @(negedge clk);
        reg_wr(2'd1, 8'd2);
        repeat (2) @(negedge clk);
        check(out_a[0] == 1'b1, "R5 pulse kept after write", int'(out_a[0]), 1);
        expect_pulse(8, 40, "R5 new duty at rollover");
        drain();
        reg_wr(2'd1, 8'd5);
        repeat (100) @(negedge clk);

        // R6 fault ends pulse; A safe low, B tri-state
        reg_wr(2'd3, 8'h02);
        wait_rise();
        repeat (2) @(negedge clk);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        check(out_a == 2'b00 && oe_a, "R6 pulse cut, A low", int'(out_a), 0);
        check(!oe_b && out_b == 2'b00, "R7 B tri-state", int'(oe_b), 0);
        read_status(st);
        check(st == 1'b1, "R6 status set", int'(st), 1);
        read_status(st);
        check(st == 1'b1, "R11 repeat read", int'(st), 1);
        // R8 clear ignored while fault high
        reg_wr(2'd3, 8'h02);
        read_status(st);
        check(st == 1'b1, "R8 clear ignored under fault", int'(st), 1);
        // R7 field variants
        reg_wr(2'd3, 8'h84);
        @(negedge clk);
        check(out_a == 2'b11 && oe_a, "R7 A high", int'(out_a), 3);
        check(out_b == 2'b00 && oe_b, "R7 B low", int'(out_b), 0);
        reg_wr(2'd3, 8'h8D);
        @(negedge clk);
        check(!oe_a && oe_b && out_b == 2'b11, "R7 A tri, B high", int'(oe_a), 0);
        reg_wr(2'd3, 8'h82);
        // R8 no self-clear without auto
        fault_in = 1'b0;
        repeat (8) @(negedge clk);
        read_status(st);
        check(st == 1'b1, "R8 stays latched", int'(st), 1);
        // R10 software clear, restart at boundary with full pulse
        expect_pulse(20, 40, "R10 full pulse after sw clear");
        reg_wr(2'd3, 8'h02);
        read_status(st);
        check(st == 1'b0, "R8 sw clear", int'(st), 0);
        check(out_a == 2'b00 && oe_a && !oe_b, "R10 still safe", int'(out_a), 0);
        drain();

        // R9 auto restart
        reg_wr(2'd2, 8'h20);
        repeat (100) @(negedge clk);
        wait_rise();
        repeat (5) @(negedge clk);
        fault_in = 1'b1;
        repeat (5) @(negedge clk);
        read_status(st);
        check(st == 1'b1, "R9 status set", int'(st), 1);
        expect_pulse(20, 40, "R10 full pulse after auto restart");
        fault_in = 1'b0;
        repeat (4) @(negedge clk);
        read_status(st);
        check(st == 1'b0, "R9 auto clear", int'(st), 0);
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule